// File: doc/BRIEF.md
# First Long Run-of-Ones Locator

This block searches one 64-bit word for the first group of adjacent 1 bits that is at least a given number of bits long. Positions are counted from the most significant end: position 0 is `data_in[63]` and position 63 is `data_in[0]`. A caller presents the word and the minimum run length together with a one-cycle `start` pulse. Some cycles later the block raises `done` for one cycle, with `found` and the starting position of the run.

Internally the search alternates two phases on a working copy of the word. The zero phase counts the leading zeros, strips them by shifting left and adds the count to a running position. The ones phase counts the leading zeros of the complemented word, which gives the length of the leading run of ones. If that length meets the minimum, the search ends with a hit. If not, the run is shifted away and the search returns to the zero phase. A zero word at the start of the zero phase ends the search with a miss. A single combinational leading-zero counter serves both phases. It works by smearing the highest set bit downward and then counting the set bits of the smeared word.

Top module: `run_locator`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), `done` and `found` are 0 and `pos` is 7'h7F.
- R2: A `start` pulse while idle captures `data_in` and `min_len`. Changes on those inputs after the capture do not affect the result.
- R3: When a run of at least `min_len` ones exists, the block reports `found`=1 and `pos` = the MSB-side index of the first bit of the earliest such run. Index p refers to `data_in[63-p]`.
- R4: An all-zero word produces `found`=0 and `pos`=7'h7F (-1 in 7-bit two's complement).
- R5: A non-zero word in which every run of ones is shorter than `min_len` produces `found`=0 and `pos`=7'h7F.
- R6: A run that ends at `data_in[0]` is measured at its full length. This includes the all-ones word, which matches every `min_len` from 1 to 64 at position 0.
- R7: `done` is high for exactly one cycle per search. `found` and `pos` stay unchanged after that cycle until the next search completes.
- R8: A `start` pulse that arrives while a search is running is ignored. The running search completes with the result for the word it captured.
- R9: `done` rises no more than 2*64+2 clock cycles after the `start` pulse. Each zero phase and each ones phase takes one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a search; sampled only while idle |
| data_in | input | 64 | Word to search; bit 63 is position 0 |
| min_len | input | 7 | Minimum run length, valid range 1 to 64 |
| done | output | 1 | One-cycle pulse: result is valid |
| found | output | 1 | 1 when a long enough run was located |
| pos | output | 7 | Start position of the run, or 7'h7F on a miss |

## Verification
The bench targets runs that touch the least significant bit, the all-ones word, and `min_len` = 64. A counter that cannot return 64 for a zero complement would report a miss or a short run there. Words whose long run comes only after several shorter runs catch a design that stops at the first run or loses the accumulated offset. A design that failed to clear the position would report a shifted index. Inputs are changed mid-search and a second `start` is injected while busy. A design that re-captured its operands would return the second word's answer. Every result's `done` is checked for width and latency, and the held outputs are checked one cycle after `done`.

// File: rtl/runfind_pkg.sv
// Package: shared types for the run-of-ones locator.
// Assumes: nothing beyond IEEE 1800-2017.
package runfind_pkg;

    // Search phase of the locator.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,   // waiting for start
        PH_ZEROS = 2'd1,   // strip leading zeros of working word
        PH_ONES  = 2'd2    // measure leading run of ones
    } phase_t;

endpackage

// File: rtl/lzc_smear.sv
// Module: lzc_smear
// Counts leading zeros of VEC_W-bit vector combinationally. The highest
// set bit is smeared toward the LSB with shift-OR stages. The set bits of
// the smeared word are then counted with a pairwise masked adder tree, and
// the count is subtracted from VEC_W. An all-zero input yields VEC_W.
// Assumes: VEC_W is a power of two, at least 2.
module lzc_smear #(
    parameter int VEC_W = 64,
    localparam int LG   = $clog2(VEC_W),
    localparam int CW   = LG + 1
) (
    input  logic [VEC_W-1:0] vec,
    output logic [CW-1:0]    zeros
);

    // Mask selecting the low half of each 2*f-bit field.
    function automatic logic [VEC_W-1:0] field_mask(input int f);
        logic [VEC_W-1:0] m;
        for (int i = 0; i < VEC_W; i++) begin
            m[i] = ((i % (2 * f)) < f);
        end
        return m;
    endfunction

    logic [VEC_W-1:0] smear [0:LG];
    logic [VEC_W-1:0] tally [0:LG];

    assign smear[0] = vec;

    // Smear stages: OR with right shifts of 1, 2, 4, ...
    generate
        for (genvar s = 0; s < LG; s++) begin : g_smear
            assign smear[s+1] = smear[s] | (smear[s] >> (1 << s));
        end
    endgenerate

    assign tally[0] = smear[LG];

    // Population count: fold neighbouring fields pairwise.
    generate
        for (genvar l = 0; l < LG; l++) begin : g_pop
            localparam int F = 1 << l;
            localparam logic [VEC_W-1:0] M = field_mask(F);
            assign tally[l+1] = (tally[l] & M) + ((tally[l] >> F) & M);
        end
    endgenerate

    logic [CW-1:0] ones_cnt;
    assign ones_cnt = tally[LG][CW-1:0];

    // Leading zeros are the bits not covered by the smear.
    assign zeros = CW'(VEC_W) - ones_cnt;

    // R6: zero input must count the full width; MSB set must count zero.
    always_comb begin
        if (!$isunknown(vec)) begin
            a_r6_full_width_zero: assert ((vec != '0) || (zeros == CW'(VEC_W)));
            a_r3_msb_set_zero:    assert (!vec[VEC_W-1] || (zeros == '0));
        end
    end

endmodule

// File: rtl/run_fsm.sv
// Module: run_fsm
// Sequences the alternating zero-strip and ones-measure phases. A search
// ends in the zero phase when the working word is empty (miss), or in the
// ones phase when the measured run meets the minimum (hit).
// Assumes: word_empty and run_long are combinational views of the
// datapath state for the current phase.
module run_fsm
    import runfind_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   word_empty,
    input  logic   run_long,
    output phase_t phase,
    output logic   finish,
    output logic   hit
);

    // End-of-search decode for the current phase.
    always_comb begin
        finish = ((phase == PH_ZEROS) && word_empty) ||
                 ((phase == PH_ONES)  && run_long);
        hit    = (phase == PH_ONES) && run_long;
    end

    // Phase register: idle -> zeros <-> ones -> idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:  if (start) phase <= PH_ZEROS;
                PH_ZEROS: phase <= word_empty ? PH_IDLE : PH_ONES;
                PH_ONES:  phase <= run_long   ? PH_IDLE : PH_ZEROS;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

    // R9: the ones phase always hands back to zeros or idle.
    a_r9_ones_leaves: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ONES) |=> (phase != PH_ONES));

endmodule

// File: rtl/run_datapath.sv
// Module: run_datapath
// Holds the working word, the captured minimum length and the running
// position. It shares one leading-zero counter between the phases: the
// word itself in the zero phase and its complement in the ones phase.
// It also registers the done/found/pos results.
// Assumes: min_len in 1..WORD_W; phase/finish/hit come from run_fsm.
module run_datapath
    import runfind_pkg::*;
#(
    parameter int WORD_W = 64,
    localparam int PW    = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase,
    input  logic              start,
    input  logic [WORD_W-1:0] data_in,
    input  logic [PW-1:0]     min_len,
    input  logic              finish,
    input  logic              hit,
    output logic              word_empty,
    output logic              run_long,
    output logic              done,
    output logic              found,
    output logic [PW-1:0]     pos
);

    logic [WORD_W-1:0] word_q;
    logic [PW-1:0]     need_q;
    logic [PW-1:0]     acc_q;
    logic [WORD_W-1:0] lz_src;
    logic [PW-1:0]     lz_cnt;
    logic [WORD_W-1:0] shifted;
    logic              advance;

    // Counter operand: complement while measuring ones.
    always_comb lz_src = (phase == PH_ONES) ? ~word_q : word_q;

    lzc_smear #(.VEC_W(WORD_W)) u_lzc (
        .vec   (lz_src),
        .zeros (lz_cnt)
    );

    // Phase decisions and the next working word.
    always_comb begin
        word_empty = (word_q == '0);
        run_long   = (lz_cnt >= need_q);
        shifted    = word_q << lz_cnt;
        advance    = ((phase == PH_ZEROS) && !word_empty) ||
                     ((phase == PH_ONES)  && !run_long);
    end

    // Working state: capture on start, then strip zeros/ones each phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            need_q <= '0;
            acc_q  <= '0;
        end else if ((phase == PH_IDLE) && start) begin
            word_q <= data_in;
            need_q <= min_len;
            acc_q  <= '0;
        end else if (advance) begin
            word_q <= shifted;
            acc_q  <= acc_q + lz_cnt;
        end
    end

    // Result registers: pulse done, hold found/pos until next finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            found <= 1'b0;
            pos   <= '1;
        end else begin
            done <= finish;
            if (finish) begin
                found <= hit;
                pos   <= hit ? acc_q : '1;
            end
        end
    end

    // R3: after the zero phase the working word leads with a one.
    a_r3_ones_head: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ONES) |-> word_q[WORD_W-1]);

    // R3: a hit always reports an in-range position.
    a_r3_hit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (pos < PW'(WORD_W)));

    // R4/R5: a miss always reports the all-ones code.
    a_r4_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (pos == '1));

    // R7: done never lasts two cycles.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: results hold between completions.
    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(pos) && $stable(found)));

    // R8: the minimum length is frozen while a search runs.
    a_r8_need_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_IDLE) |=> $stable(need_q));

endmodule

// File: rtl/run_locator.sv
// Module: run_locator (top)
// Locates the first run of at least min_len adjacent ones in a 64-bit
// word, counting positions from the MSB. start/done handshake; one
// search at a time; a miss reports all ones on pos.
// Assumes: start is honoured only while idle; min_len in 1..WORD_W.
module run_locator
    import runfind_pkg::*;
#(
    parameter int WORD_W = 64,
    localparam int PW    = $clog2(WORD_W) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] data_in,
    input  logic [PW-1:0]     min_len,
    output logic              done,
    output logic              found,
    output logic [PW-1:0]     pos
);

    phase_t phase;
    logic   finish;
    logic   hit;
    logic   word_empty;
    logic   run_long;

    run_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .word_empty (word_empty),
        .run_long   (run_long),
        .phase      (phase),
        .finish     (finish),
        .hit        (hit)
    );

    run_datapath #(.WORD_W(WORD_W)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (phase),
        .start      (start),
        .data_in    (data_in),
        .min_len    (min_len),
        .finish     (finish),
        .hit        (hit),
        .word_empty (word_empty),
        .run_long   (run_long),
        .done       (done),
        .found      (found),
        .pos        (pos)
    );

    // R2: a search begins only from idle.
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_IDLE) && start) |=> (phase == PH_ZEROS));

endmodule

// File: tb/test_run_locator.sv
module test_run_locator;

    localparam int W        = 64;
    localparam int PW       = 7;
    localparam int MAX_LAT  = 2 * W + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  data_in = '0;
    logic [PW-1:0] min_len = 7'd1;
    logic          done;
    logic          found;
    logic [PW-1:0] pos;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;   // 125 MHz

    run_locator #(.WORD_W(W)) i_run_locator (
        .clk(clk), .rst_n(rst_n), .start(start), .data_in(data_in),
        .min_len(min_len), .done(done), .found(found), .pos(pos)
    );

    // Bit-by-bit reference scan from the MSB side; -1 when no run qualifies.
    function automatic int ref_pos(input logic [W-1:0] w, input int n);
        int run = 0;
        for (int p = 0; p < W; p++) begin
            if (w[W-1-p]) begin
                run++;
                if (run == n) return p - n + 1;
            end else begin
                run = 0;
            end
        end
        return -1;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // mode 0: plain; 1: scramble inputs after start (R2); 2: second start while busy (R8)
    task automatic search(input logic [W-1:0] w, input int n, input int mode,
                          input string req);
        int exp_p;
        logic [PW-1:0] exp_code;
        int lat;
        exp_p    = ref_pos(w, n);
        exp_code = (exp_p < 0) ? 7'h7F : PW'(exp_p);
        @(negedge clk);
        data_in = w;
        min_len = PW'(n);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        if (mode != 0) begin
            data_in = ~w;
            min_len = 7'd1;
            if (mode == 2) start = 1'b1;
        end
        while (!done && lat <= MAX_LAT) begin
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        start = 1'b0;
        check(done === 1'b1, "R9", "done within latency bound", lat, MAX_LAT);
        check(found === (exp_p >= 0), req, "found", found, (exp_p >= 0));
        check(pos === exp_code, req, "pos", pos, exp_code);
        @(negedge clk);
        check(done === 1'b0, "R7", "done width one cycle", done, 0);
        check(pos === exp_code && found === (exp_p >= 0), "R7",
              "result held after done", pos, exp_code);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [W-1:0] a, b, c, w;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(done === 1'b0, "R1", "done after reset", done, 0);
        check(found === 1'b0, "R1", "found after reset", found, 0);
        check(pos === 7'h7F, "R1", "pos after reset", pos, 7'h7F);

        // Directed corner cases
        search(64'h0F00_0000_0000_0000, 4, 0, "R3");
        search(64'h0, 4, 0, "R4");
        search(64'h0, 1, 0, "R4");
        search('1, 64, 0, "R6");
        search('1, 1, 0, "R6");
        search(64'h0000_0000_0000_000F, 4, 0, "R6");
        search(64'h0000_0000_0000_000F, 5, 0, "R5");
        search(64'h8000_0000_0000_0001, 1, 0, "R3");
        search(64'h8000_0000_0000_0001, 2, 0, "R5");
        search(64'hAAAA_AAAA_AAAA_AAAA, 2, 0, "R5");
        search(64'h7FFF_FFFF_FFFF_FFFF, 63, 0, "R6");
        search(64'hE0F0_0000_0000_03FF, 5, 0, "R3");
        search(64'h0123_4567_89AB_CDEF, 4, 0, "R3");
        // R2: inputs changed after capture
        search(64'h00F0_0000_0000_0F00, 8, 1, "R2");
        search(64'hF000_0000_0000_0000, 5, 1, "R2");
        // R8: start while busy
        search(64'h3000_0000_0001_FF00, 9, 2, "R8");
        search(64'h0000_0000_0000_0000, 3, 2, "R8");

        // Constrained random: mixed densities, every n from 1 to 64
        for (int i = 0; i < 600; i++) begin
            a = {$urandom, $urandom};
            b = {$urandom, $urandom};
            c = {$urandom, $urandom};
            case (i % 4)
                0: w = a & b;
                1: w = a | b;
                2: w = a | b | c;
                default: w = ~(64'h1 << (a[5:0])) & ~(64'h1 << (b[5:0]));
            endcase
            search(w, (i % 64) + 1, 0, "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule